// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a small 32-bit processor that completes one instruction on every enabled clock edge. It decodes seven operations: register add, register subtract, OR with an immediate, word load, word store, branch on equal and an absolute jump. Its datapath covers the program counter, a sum-of-products decoder, a 32-entry register file, a three-function ALU, an immediate extender and the next-address logic. The instruction and data stores are word arrays inside the block.

Programs are written into the instruction store through a load port while `run` is low. Execution then advances one instruction for each rising clock edge with `run` high. The program counter is a port. Any register can be read combinationally through a debug select, so the architectural state can be observed from outside.

Instruction fields: opcode in bits 31..26, first source in 25..21, second source (the destination for immediate forms) in 20..16, register destination in 15..11, immediate in 15..0, function code in 5..0 and jump target in 25..0. A 2-bit ALU code selects the operation: 00 add, 01 subtract, 10 OR. Bit 0 of the code is set for subtract and beq, and bit 1 for ori.

Top module: `sc_core`

## Requirements
- R1: After reset is released, the program counter reads 0.
- R2: Opcode 000000 with function 100000 writes rs+rt to rd, and function 100010 writes rs-rt to rd. Both advance the program counter by 4.
- R3: Opcode 001101 writes rs OR the zero-extended 16-bit immediate to rt.
- R4: Opcode 100011 loads rt from the data word addressed by rs plus the sign-extended immediate. Address bits 1..0 are ignored, and the word index wraps at the store depth.
- R5: Opcode 101011 stores rt to the data word addressed by rs plus the sign-extended immediate. It writes no register.
- R6: Opcode 000100 sets the next address to PC+4 plus the sign-extended immediate shifted left by 2 when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 000010 sets the next address to bits 31..28 of PC+4, followed by the 26-bit target, followed by two zero bits.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode, and an R-type instruction whose function code is neither 100000 nor 100010, changes no register and no data word. Such an instruction only advances the program counter by 4.
- R10: While `run` is low, the program counter and the registers hold. A write on the load port places a word in the instruction store at the given word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Clock enable: execute one instruction per edge when high |
| load_we | input | 1 | Write strobe for the instruction store |
| load_addr | input | log2(IMEM_DEPTH) (8) | Word index of the instruction to write |
| load_data | input | 32 | Instruction word to write |
| pc | output | 32 | Current program counter |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Combinational contents of register `dbg_sel` |

## Verification
Two things can land on the same edge. A register write can coincide with a change of the program counter on a taken branch or a jump. A load-port write can coincide with the core holding still. The bench creates each instruction at run time from a reference model. It writes the instruction at the model's next address while `run` is low, checks that the program counter and a watched register stay unchanged, and then lets the core execute exactly one edge. After that edge it compares both the new program counter and the destination register against the model. Load offsets are computed from live register values, so the sign-extended effective address lands on store words that have already been written, and branch operands are sometimes chosen equal so that taken and not-taken paths are both exercised.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_write;
    logic    br_sel;
    logic    jmp_sel;
    logic    sext;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] fn,
  output ctrl_t      ctrl
);
  logic t_rtype, t_ori, t_lw, t_sw, t_beq, t_jmp, t_add, t_sub;

  // product terms: one AND plane entry per instruction
  always_comb begin
    t_rtype = ~op[5] & ~op[4] & ~op[3] & ~op[2] & ~op[1] & ~op[0];
    t_ori   = ~op[5] & ~op[4] &  op[3] &  op[2] & ~op[1] &  op[0];
    t_lw    =  op[5] & ~op[4] & ~op[3] & ~op[2] &  op[1] &  op[0];
    t_sw    =  op[5] & ~op[4] &  op[3] & ~op[2] &  op[1] &  op[0];
    t_beq   = ~op[5] & ~op[4] & ~op[3] &  op[2] & ~op[1] & ~op[0];
    t_jmp   = ~op[5] & ~op[4] & ~op[3] & ~op[2] &  op[1] & ~op[0];
    t_add   = t_rtype & fn[5] & ~fn[4] & ~fn[3] & ~fn[2] & ~fn[1] & ~fn[0];
    t_sub   = t_rtype & fn[5] & ~fn[4] & ~fn[3] & ~fn[2] &  fn[1] & ~fn[0];
  end

  // OR plane
  always_comb begin
    ctrl.reg_dst    = t_add | t_sub;
    ctrl.alu_src    = t_ori | t_lw | t_sw;
    ctrl.mem_to_reg = t_lw;
    ctrl.reg_write  = t_add | t_sub | t_ori | t_lw;
    ctrl.mem_write  = t_sw;
    ctrl.br_sel     = t_beq;
    ctrl.jmp_sel    = t_jmp;
    ctrl.sext       = t_lw | t_sw;
    ctrl.alu_op     = alu_op_e'({t_ori, t_sub | t_beq});
  end

  always_comb begin
    if (!$isunknown({op, fn})) begin
      a_r5_store_quiet: assert (!(ctrl.mem_write && ctrl.reg_write))
        else $error("store raised a register write");
      a_r9_unknown_quiet: assert (t_add || t_sub || t_ori || t_lw || t_sw || t_beq || t_jmp
                                  || !(ctrl.reg_write || ctrl.mem_write || ctrl.br_sel || ctrl.jmp_sel))
        else $error("unknown encoding raised an enable");
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
    zero = (y == '0);
  end

  always_comb begin
    if (!$isunknown({a, b, op}) && op == ALU_SUB) begin
      a_r6_zero_means_equal: assert (zero == (a == b))
        else $error("zero flag disagrees with operand compare");
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
  end
endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc #(
  parameter int W    = 32,
  parameter int IMMW = 16,
  parameter int TGTW = 26,
  localparam int SHW = W - TGTW - 2,
  localparam int EXW = W - IMMW - 2
) (
  input  logic [W-1:0]    pc,
  input  logic [IMMW-1:0] imm,
  input  logic [TGTW-1:0] tgt,
  input  logic            br_take,
  input  logic            jmp,
  output logic [W-1:0]    pc_plus4,
  output logic [W-1:0]    pc_next
);
  logic [W-1:0] br_off;

  always_comb begin
    pc_plus4 = pc + W'(4);
    br_off   = {{EXW{imm[IMMW-1]}}, imm, 2'b00};
    if (jmp)          pc_next = {pc_plus4[W-1 -: SHW], tgt, 2'b00};
    else if (br_take) pc_next = pc_plus4 + br_off;
    else              pc_next = pc_plus4;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          load_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] load_addr,
  input  logic [31:0]                   load_data,
  output logic [31:0]                   pc,
  input  logic [4:0]                    dbg_sel,
  output logic [31:0]                   dbg_data
);
  localparam int IAW  = $clog2(IMEM_DEPTH);
  localparam int DAW  = $clog2(DMEM_DEPTH);
  localparam int RAW  = 5;
  localparam int NREG = 1 << RAW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // program counter
  logic [XLEN-1:0] pc_q, pc_d, pc_next, pc_plus4;
  always_comb pc_d = run ? pc_next : pc_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end
  assign pc = pc_q;

  // instruction store
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] instr;
  always_ff @(posedge clk) begin
    if (load_we) imem[load_addr] <= load_data;
  end
  assign instr = imem[pc_q[2 +: IAW]];

  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [15:0]    f_imm;
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  ctrl_t ctrl;
  sc_decode u_dec (.op(instr[31:26]), .fn(instr[5:0]), .ctrl(ctrl));

  // register file: ports 0/1 feed the datapath, port 2 is the debug read
  logic [2:0][RAW-1:0]  rf_ra;
  logic [2:0][XLEN-1:0] rf_rd;
  logic [RAW-1:0]       wr_addr;
  logic [XLEN-1:0]      wr_data, ext_imm, alu_b, alu_y, dm_rd;
  logic                 alu_zero, take_br;

  assign rf_ra = {dbg_sel, f_rt, f_rs};

  sc_regfile #(.NREG(NREG), .W(XLEN), .NRD(3)) u_rf (
    .clk(clk), .we(run && ctrl.reg_write), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rf_ra), .rdata(rf_rd)
  );
  assign dbg_data = rf_rd[2];

  always_comb begin
    ext_imm = ctrl.sext ? {{16{f_imm[15]}}, f_imm} : {16'b0, f_imm};
    alu_b   = ctrl.alu_src ? ext_imm : rf_rd[1];
  end

  sc_alu #(.W(XLEN)) u_alu (.a(rf_rd[0]), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero));

  // data store
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  always_ff @(posedge clk) begin
    if (run && ctrl.mem_write) dmem[alu_y[2 +: DAW]] <= rf_rd[1];
  end
  assign dm_rd = dmem[alu_y[2 +: DAW]];

  always_comb begin
    wr_addr = ctrl.reg_dst ? f_rd : f_rt;
    wr_data = ctrl.mem_to_reg ? dm_rd : alu_y;
    take_br = ctrl.br_sel & alu_zero;
  end

  sc_nextpc #(.W(XLEN), .IMMW(16), .TGTW(26)) u_npc (
    .pc(pc_q), .imm(f_imm), .tgt(instr[25:0]), .br_take(take_br), .jmp(ctrl.jmp_sel),
    .pc_plus4(pc_plus4), .pc_next(pc_next)
  );

  a_r10_hold_pc: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |=> $stable(pc_q))
    else $error("pc moved while run was low");

  a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_core_n)
    run && !take_br && !ctrl.jmp_sel |=> pc_q == $past(pc_q) + 32'd4)
    else $error("non-transfer instruction did not advance pc by 4");

  a_r7_jump_region: assert property (@(posedge clk) disable iff (!rst_core_n)
    run && ctrl.jmp_sel |=> pc_q[31:28] == $past(pc_plus4[31:28]) && pc_q[1:0] == 2'b00)
    else $error("jump left its region or lost alignment");

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_core_n)
    dbg_sel == '0 |-> dbg_data == '0)
    else $error("register 0 read nonzero");
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int IAW = 8;
  localparam int DAW = 5;
  localparam int NRAND = 700;

  logic clk = 1'b0;
  logic rst_n, run, load_we;
  logic [IAW-1:0] load_addr;
  logic [31:0] load_data, pc, dbg_data;
  logic [4:0] dbg_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core #(.IMEM_DEPTH(1 << IAW), .DMEM_DEPTH(1 << DAW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .pc(pc), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] rm [32];
  bit          rv [32];
  logic [31:0] dm [1 << DAW];
  bit          dv [1 << DAW];
  logic [31:0] pcm;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [4:0] pick_src();
    for (int k = 0; k < 8; k++) begin
      logic [4:0] r = 5'($urandom % 32);
      if (rv[r]) return r;
    end
    return 5'd0;
  endfunction

  function automatic logic [31:0] gen();
    int          kind = int'($urandom % 16);
    logic [4:0]  rs = pick_src();
    logic [4:0]  rt = pick_src();
    logic [4:0]  rd = 5'($urandom % 32);
    logic [15:0] imm;
    if (kind >= 8 && kind <= 9) begin
      for (int k = 0; k < 8; k++) begin
        int idx = int'($urandom % (1 << DAW));
        if (dv[idx]) begin
          imm = 16'(idx * 4 + int'($urandom % 4)) - rm[rs][15:0];
          return {6'h23, rs, rd, imm};
        end
      end
      kind = 10;
    end
    if (kind <= 2) return {6'h00, rs, rt, rd, 5'h0, 6'h20};
    if (kind <= 4) return {6'h00, rs, rt, rd, 5'h0, 6'h22};
    if (kind <= 7) return {6'h0d, rs, rd, 16'($urandom)};
    if (kind <= 11) begin
      imm = 16'(($urandom % (1 << DAW)) * 4) - rm[rs][15:0];
      return {6'h2b, rs, rt, imm};
    end
    if (kind <= 13) begin
      if ($urandom % 2 == 0) rt = rs;
      imm = 16'(int'($urandom % 13) - 6);
      return {6'h04, rs, rt, imm};
    end
    if (kind == 14) return {6'h02, 26'($urandom)};
    if ($urandom % 2 == 0) begin
      logic [5:0] f = 6'($urandom);
      if (f == 6'h20 || f == 6'h22) f = 6'h24;
      return {6'h00, rs, rt, rd, 5'h0, f};
    end
    case ($urandom % 4)
      0: return {6'h08, rs, rt, 16'($urandom)};
      1: return {6'h0c, rs, rt, 16'($urandom)};
      2: return {6'h2a, rs, rt, 16'($urandom)};
      default: return {6'h3f, rs, rt, 16'($urandom)};
    endcase
  endfunction

  // load one word at the model's pc, hold, then execute one edge
  task automatic step(input logic [31:0] ins);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [4:0]  rs = ins[25:21];
    logic [4:0]  rt = ins[20:16];
    logic [4:0]  rd = ins[15:11];
    logic [15:0] imm = ins[15:0];
    logic [31:0] a = rm[rs];
    logic [31:0] b = rm[rt];
    logic [31:0] pc4 = pcm + 32'd4;
    logic [31:0] npc = pc4;
    logic [31:0] ad, val = '0;
    bit          wr = 0, vv = 1;
    logic [4:0]  dst = '0, watch = rt;
    string       tag = "R9 unknown";
    case (op)
      6'h00: begin
        watch = rd;
        if (fn == 6'h20) begin wr = 1; dst = rd; val = a + b; tag = "R2 add"; end
        else if (fn == 6'h22) begin wr = 1; dst = rd; val = a - b; tag = "R2 sub"; end
        else tag = "R9 funct";
      end
      6'h0d: begin wr = 1; dst = rt; val = a | {16'b0, imm}; tag = "R3 ori"; end
      6'h23: begin
        ad = a + sx(imm); wr = 1; dst = rt;
        val = dm[ad[2 +: DAW]]; vv = dv[ad[2 +: DAW]]; tag = "R4 load";
      end
      6'h2b: tag = "R5 store";
      6'h04: begin
        watch = rs; tag = "R6 branch";
        if (a == b) npc = pc4 + {sx(imm)[29:0], 2'b00};
      end
      6'h02: begin npc = {pc4[31:28], ins[25:0], 2'b00}; tag = "R7 jump"; end
      default: ;
    endcase
    if (wr) begin
      watch = dst;
      if (dst == 5'd0) tag = "R8 r0 write";
    end

    @(negedge clk);
    load_we = 1'b1; load_addr = pcm[2 +: IAW]; load_data = ins; dbg_sel = watch;
    @(negedge clk);
    load_we = 1'b0;
    chk("R10 pc hold", pc, pcm);
    if (rv[watch]) chk("R10 reg hold", dbg_data, rm[watch]);

    if (op == 6'h2b) begin
      ad = a + sx(imm);
      dm[ad[2 +: DAW]] = b; dv[ad[2 +: DAW]] = rv[rt];
    end
    if (wr && dst != 5'd0) begin rm[dst] = val; rv[dst] = vv; end
    pcm = npc;

    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    chk({tag, " pc"}, pc, pcm);
    if (rv[watch]) chk({tag, " reg"}, dbg_data, rm[watch]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; run = 1'b0; load_we = 1'b0; load_addr = '0; load_data = '0; dbg_sel = '0;
    for (int i = 0; i < 32; i++) begin rm[i] = '0; rv[i] = (i == 0); end
    for (int i = 0; i < (1 << DAW); i++) begin dm[i] = '0; dv[i] = 0; end
    pcm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc, 32'd0);
    chk("R8 r0 after reset", dbg_data, 32'd0);

    // directed corners
    step({6'h0d, 5'd0, 5'd1, 16'h8001});              // R3 high immediate bit not extended
    step({6'h0d, 5'd0, 5'd2, 16'h0003});
    step({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20});      // R2 add
    step({6'h00, 5'd2, 5'd1, 5'd4, 5'd0, 6'h22});      // R2 sub to negative
    step({6'h2b, 5'd0, 5'd4, 16'hfffc});               // R5 negative offset -> word 31
    step({6'h23, 5'd0, 5'd5, 16'h007c});               // R4 read word 31 back
    step({6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h20});      // R8 write to r0 dropped
    step({6'h00, 5'd1, 5'd2, 5'd1, 5'd0, 6'h24});      // R9 unsupported funct
    step({6'h08, 5'd1, 5'd2, 16'h0001});               // R9 unsupported opcode
    step({6'h04, 5'd1, 5'd1, 16'h0002});               // R6 taken forward
    step({6'h04, 5'd1, 5'd2, 16'hfffd});               // R6 not taken
    step({6'h04, 5'd2, 5'd2, 16'hfffc});               // R6 taken backward
    step({6'h02, 26'h3ff_ffff});                       // R7 full target field
    step({6'h02, 26'h000_0010});

    for (int n = 0; n < NRAND; n++) step(gen());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule